// File: doc/BRIEF.md
# Transmit Impedance Calibration Sequencer

This block runs a fixed register-level procedure that retunes a serial transmitter's output impedance. After a start pulse it reads the resistor-tune result from the PHY's register space and adds a fixed offset to it. The sum is limited to a ceiling. The block then forces the adjusted code back into the tune-debug register as a manual override value. While that happens, the transmitter's reset is placed under override and then pulsed.

All register traffic uses a simple request/acknowledge command port that carries 16-bit data. An external port master performs each access. The sequencer keeps working copies of the two registers it modifies. Later writes in the procedure are built from these copies, so each register is read only once. The block reports progress on a busy level and signals completion with a done pulse.

Top module: `txcal_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start, `busy`, `done` and `cmd_req` are 0.
- R2: A `start` seen while idle raises `busy` and `cmd_req` in the next cycle. A `start` seen while busy has no effect, and the running procedure continues unchanged.
- R3: A command's `cmd_write`, `cmd_addr` and `cmd_wdata` stay stable while `cmd_req` is high and `cmd_ack` is low. A one-cycle `cmd_ack` completes the command, and the next command is presented in the following cycle. A `cmd_ack` while idle is ignored.
- R4: The first command reads address 0x0003 (`cmd_write`=0). The second writes that value back to 0x0003 with bits [4:3] set to 2'b10 and every other bit unchanged.
- R5: The third command reads 0x0004. The new code is bits [9:0] of the returned data plus 8, limited to 63. Bits [15:10] of the returned data have no effect.
- R6: The fourth command reads 0x1001. The fifth writes that value to 0x1001 with bit 7 set.
- R7: The sixth command writes the working 0x0003 value with bit 1 cleared.
- R8: The seventh command writes the working 0x0003 value with bits [13:5] replaced by the new code, zero-extended.
- R9: The eighth and ninth commands write the working 0x0003 value with bit 2 at 1 and then at 0.
- R10: The tenth and eleventh commands write the working 0x1001 value with bit 6 at 1 and then at 0. No further command follows.
- R11: Exactly three reads are issued. Every write is derived from the working copies and not from a fresh read.
- R12: In the cycle after the eleventh command's acknowledge, `done` is 1 for exactly one cycle, and `busy` and `cmd_req` are 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the calibration procedure |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_req | output | 1 | Command pending on the register port |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_ack | input | 1 | Command completed (one cycle) |
| cmd_rdata | input | DATA_W | Read data, valid with `cmd_ack` on a read |

## Verification
Some properties are checked on every cycle. Command fields must stay stable while a request waits. Busy may only rise after a start, and an idle block stays idle without one. Every write to 0x0003 must carry the type value 2 and every write to 0x1001 must carry the override bit. The done pulse must be a single cycle and must follow the acknowledge of the final transmit-reset write. Other behaviours only the bench scenarios can show: the exact order and contents of all eleven commands, the offset-and-saturate arithmetic on the status value, the point where the upper status bits are ignored, and the immunity to a mid-run start or a stray idle acknowledge. The bench shows these by replaying the procedure with different register contents and port latencies.

// File: rtl/txcal_pkg.sv
package txcal_pkg;

  localparam logic [15:0] TUNE_ADDR = 16'h0003;
  localparam logic [15:0] STAT_ADDR = 16'h0004;
  localparam logic [15:0] TXO_ADDR  = 16'h1001;

  localparam int TYPE_LSB     = 3;
  localparam logic [1:0] TYPE_VAL = 2'b10;
  localparam int MAN_BIT      = 1;
  localparam int SETV_BIT     = 2;
  localparam int VAL_LSB      = 5;
  localparam int VAL_W        = 9;
  localparam int TXOVR_BIT    = 7;
  localparam int TXRST_BIT    = 6;

  typedef enum logic [3:0] {
    ST_RD_TUNE   = 4'd0,
    ST_WR_TYPE   = 4'd1,
    ST_RD_STAT   = 4'd2,
    ST_RD_TXO    = 4'd3,
    ST_WR_TXOVR  = 4'd4,
    ST_WR_NOMAN  = 4'd5,
    ST_WR_VAL    = 4'd6,
    ST_WR_SET1   = 4'd7,
    ST_WR_SET0   = 4'd8,
    ST_WR_TXRST1 = 4'd9,
    ST_WR_TXRST0 = 4'd10
  } step_e;

  typedef enum logic [1:0] {
    SEL_TUNE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXO  = 2'd2
  } sel_e;

  typedef enum logic {
    FSM_IDLE = 1'b0,
    FSM_RUN  = 1'b1
  } fsm_e;

endpackage

// File: rtl/txcal_code_sat.sv
module txcal_code_sat
  import txcal_pkg::*;
#(
  parameter int STAT_W   = 10,
  parameter int OFFSET   = 8,
  parameter int CODE_MAX = 63,
  localparam int CODE_W  = $clog2(CODE_MAX + 1)
) (
  input  logic [STAT_W-1:0] raw,
  output logic [CODE_W-1:0] code
);
  localparam int SUM_W = STAT_W + 1;

  logic [SUM_W-1:0] sum;

  generate
    if (OFFSET == 0) begin : g_no_offset
      assign sum = {1'b0, raw};
    end else begin : g_offset
      assign sum = {1'b0, raw} + SUM_W'(OFFSET);
    end
  endgenerate

  always_comb begin
    if (sum > SUM_W'(CODE_MAX)) code = CODE_W'(CODE_MAX);
    else                        code = sum[CODE_W-1:0];
  end

endmodule

// File: rtl/txcal_step_decode.sv
module txcal_step_decode
  import txcal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_W = 6
) (
  input  step_e              step,
  input  logic [DATA_W-1:0]  tune_w,
  input  logic [DATA_W-1:0]  txo_w,
  input  logic [CODE_W-1:0]  code,
  output logic               wr,
  output sel_e               sel,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  wdata
);

  always_comb begin
    wr    = 1'b1;
    sel   = SEL_TUNE;
    wdata = tune_w;
    unique case (step)
      ST_RD_TUNE: begin
        wr = 1'b0;
      end
      ST_WR_TYPE: begin
        wdata[TYPE_LSB +: 2] = TYPE_VAL;
      end
      ST_RD_STAT: begin
        wr  = 1'b0;
        sel = SEL_STAT;
      end
      ST_RD_TXO: begin
        wr    = 1'b0;
        sel   = SEL_TXO;
        wdata = txo_w;
      end
      ST_WR_TXOVR: begin
        sel   = SEL_TXO;
        wdata = txo_w;
        wdata[TXOVR_BIT] = 1'b1;
      end
      ST_WR_NOMAN: begin
        wdata[MAN_BIT] = 1'b0;
      end
      ST_WR_VAL: begin
        wdata[VAL_LSB +: VAL_W] = VAL_W'(code);
      end
      ST_WR_SET1: begin
        wdata[SETV_BIT] = 1'b1;
      end
      ST_WR_SET0: begin
        wdata[SETV_BIT] = 1'b0;
      end
      ST_WR_TXRST1: begin
        sel   = SEL_TXO;
        wdata = txo_w;
        wdata[TXRST_BIT] = 1'b1;
      end
      ST_WR_TXRST0: begin
        sel   = SEL_TXO;
        wdata = txo_w;
        wdata[TXRST_BIT] = 1'b0;
      end
      default: begin
        wr = 1'b0;
      end
    endcase
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: addr = ADDR_W'(STAT_ADDR);
      SEL_TXO:  addr = ADDR_W'(TXO_ADDR);
      default:  addr = ADDR_W'(TUNE_ADDR);
    endcase
  end

endmodule

// File: rtl/txcal_work_regs.sv
module txcal_work_regs
  import txcal_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              wr,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [CODE_W-1:0] new_code,
  output logic [DATA_W-1:0] tune_w,
  output logic [DATA_W-1:0] txo_w,
  output logic [CODE_W-1:0] code
);

  logic [DATA_W-1:0] tune_d, txo_d;
  logic [CODE_W-1:0] code_d;
  logic              tune_en, txo_en, code_en;

  always_comb begin
    tune_en = upd_en && (sel == SEL_TUNE);
    txo_en  = upd_en && (sel == SEL_TXO);
    code_en = upd_en && (sel == SEL_STAT) && !wr;
    tune_d  = wr ? wdata : rdata;
    txo_d   = wr ? wdata : rdata;
    code_d  = new_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_w <= '0;
      txo_w  <= '0;
      code   <= '0;
    end else begin
      if (tune_en) tune_w <= tune_d;
      if (txo_en)  txo_w  <= txo_d;
      if (code_en) code   <= code_d;
    end
  end

endmodule

// File: rtl/txcal_seq.sv
module txcal_seq
  import txcal_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int STAT_W   = 10,
  parameter int OFFSET   = 8,
  parameter int CODE_MAX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              cmd_req,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  input  logic [DATA_W-1:0] cmd_rdata
);
  localparam int CODE_W = $clog2(CODE_MAX + 1);

  fsm_e  state_q, state_d;
  step_e step_q, step_d;
  logic  done_q, done_d;

  logic [DATA_W-1:0] tune_w, txo_w;
  logic [CODE_W-1:0] code, new_code;
  sel_e              sel;
  logic              upd_en;

  txcal_code_sat #(
    .STAT_W  (STAT_W),
    .OFFSET  (OFFSET),
    .CODE_MAX(CODE_MAX)
  ) sat_i (
    .raw (cmd_rdata[STAT_W-1:0]),
    .code(new_code)
  );

  txcal_step_decode #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) dec_i (
    .step  (step_q),
    .tune_w(tune_w),
    .txo_w (txo_w),
    .code  (code),
    .wr    (cmd_write),
    .sel   (sel),
    .addr  (cmd_addr),
    .wdata (cmd_wdata)
  );

  assign upd_en = (state_q == FSM_RUN) && cmd_ack;

  txcal_work_regs #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .wr      (cmd_write),
    .sel     (sel),
    .wdata   (cmd_wdata),
    .rdata   (cmd_rdata),
    .new_code(new_code),
    .tune_w  (tune_w),
    .txo_w   (txo_w),
    .code    (code)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    unique case (state_q)
      FSM_IDLE: begin
        if (start) begin
          state_d = FSM_RUN;
          step_d  = ST_RD_TUNE;
        end
      end
      FSM_RUN: begin
        if (cmd_ack) begin
          if (step_q == ST_WR_TXRST0) begin
            state_d = FSM_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_e'(step_q + 4'd1);
          end
        end
      end
      default: state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      step_q  <= ST_RD_TUNE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q == FSM_RUN);
  assign cmd_req = (state_q == FSM_RUN);
  assign done    = done_q;

endmodule

// File: rtl/txcal_seq_chk.sv
module txcal_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cmd_req,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              cmd_ack
);

  assert_hold_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_write) &&
                               $stable(cmd_addr) && $stable(cmd_wdata)));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_idle_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_type_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_write && cmd_addr == ADDR_W'(16'h0003)) |-> (cmd_wdata[4:3] == 2'b10));

  assert_txovr_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_write && cmd_addr == ADDR_W'(16'h1001)) |-> cmd_wdata[7]);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_req));

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd_ack) && $past(cmd_write) &&
              $past(cmd_addr) == ADDR_W'(16'h1001) && !$past(cmd_wdata[6])));

endmodule

bind txcal_seq txcal_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cmd_req  (cmd_req),
  .cmd_write(cmd_write),
  .cmd_addr (cmd_addr),
  .cmd_wdata(cmd_wdata),
  .cmd_ack  (cmd_ack)
);

// File: tb/txcal_seq_tb_top.sv
module txcal_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        busy, done, cmd_req, cmd_write;
  logic [15:0] cmd_addr, cmd_wdata;
  logic        cmd_ack;
  logic [15:0] cmd_rdata;

  txcal_seq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cmd_req  (cmd_req),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .cmd_ack  (cmd_ack),
    .cmd_rdata(cmd_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int errors  = 0;

  // reference model state
  logic [32:0] exp_q[$];
  logic [15:0] m_tune, m_stat, m_txo;
  logic [15:0] fin_tune, fin_txo;
  logic        mb, md;
  int          nacked, wcnt, lat_base, nreads;

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] t3, input logic [15:0] s4, input logic [15:0] x1);
    logic [15:0] tw, xw;
    int c;
    exp_q.delete();
    tw = t3;
    exp_q.push_back({1'b0, 16'h0003, 16'h0});                // R4
    tw[4:3] = 2'b10;
    exp_q.push_back({1'b1, 16'h0003, tw});                   // R4
    exp_q.push_back({1'b0, 16'h0004, 16'h0});                // R5
    c = int'(s4[9:0]) + 8;
    if (c > 63) c = 63;
    xw = x1;
    exp_q.push_back({1'b0, 16'h1001, 16'h0});                // R6
    xw[7] = 1'b1;
    exp_q.push_back({1'b1, 16'h1001, xw});                   // R6
    tw[1] = 1'b0;
    exp_q.push_back({1'b1, 16'h0003, tw});                   // R7
    tw[13:5] = 9'(c);
    exp_q.push_back({1'b1, 16'h0003, tw});                   // R8
    tw[2] = 1'b1;
    exp_q.push_back({1'b1, 16'h0003, tw});                   // R9
    tw[2] = 1'b0;
    exp_q.push_back({1'b1, 16'h0003, tw});                   // R9
    xw[6] = 1'b1;
    exp_q.push_back({1'b1, 16'h1001, xw});                   // R10
    xw[6] = 1'b0;
    exp_q.push_back({1'b1, 16'h1001, xw});                   // R10
    fin_tune = tw;
    fin_txo  = xw;
  endtask

  task automatic tick();
    logic [32:0] e;
    @(negedge clk);
    // model update from the inputs seen at the last edge
    if (md) md = 1'b0;
    if (mb && cmd_ack && nacked == 11) begin
      mb = 1'b0;
      md = 1'b1;
    end else if (!mb && start) begin
      mb = 1'b1;
    end
    cmp("R2 busy", {31'd0, busy}, {31'd0, mb});
    cmp("R12 done", {31'd0, done}, {31'd0, md});
    cmp("R3 cmd_req", {31'd0, cmd_req}, {31'd0, mb});
    // port master
    if (cmd_ack) begin
      cmd_ack = 1'b0;
      wcnt = 0;
    end else if (cmd_req) begin
      if (wcnt >= (lat_base + nacked) % 4) begin
        if (exp_q.size() == 0) begin
          cmp("R10 extra command", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          cmp("R3 cmd_write", {31'd0, cmd_write}, {31'd0, e[32]});
          cmp("R3 cmd_addr", {16'd0, cmd_addr}, {16'd0, e[31:16]});
          if (e[32]) cmp("R4-R10 cmd_wdata", {16'd0, cmd_wdata}, {16'd0, e[15:0]});
        end
        if (cmd_write) begin
          case (cmd_addr)
            16'h0003: m_tune = cmd_wdata;
            16'h1001: m_txo  = cmd_wdata;
            default:  m_stat = cmd_wdata;
          endcase
          cmd_rdata = 16'hDEAD;
        end else begin
          nreads++;
          case (cmd_addr)
            16'h0003: cmd_rdata = m_tune;
            16'h0004: cmd_rdata = m_stat;
            default:  cmd_rdata = m_txo;
          endcase
        end
        cmd_ack = 1'b1;
        nacked++;
      end else begin
        wcnt++;
      end
    end
  endtask

  task automatic run(input logic [15:0] t3, input logic [15:0] s4, input logic [15:0] x1,
                     input int lat, input bit mid_start);
    int n;
    m_tune = t3; m_stat = s4; m_txo = x1;
    build(t3, s4, x1);
    nacked = 0; wcnt = 0; nreads = 0; lat_base = lat;
    start = 1'b1;
    tick();
    start = 1'b0;
    n = 0;
    while (!md && n < 300) begin
      tick();
      n++;
      if (mid_start && n == 6) start = 1'b1;   // R2: ignored while busy
      else start = 1'b0;
    end
    if (!md) cmp("R12 done never seen", 32'd0, 32'd1);
    tick();
    tick();
    cmp("R10 commands left", exp_q.size(), 32'd0);
    cmp("R11 read count", nreads, 32'd3);
    cmp("R9 final tune reg", {16'd0, m_tune}, {16'd0, fin_tune});
    cmp("R10 final txo reg", {16'd0, m_txo}, {16'd0, fin_txo});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_ack = 1'b0; cmd_rdata = 16'h0;
    mb = 1'b0; md = 1'b0; nacked = 0; wcnt = 0; lat_base = 0; nreads = 0;
    m_tune = '0; m_stat = '0; m_txo = '0; fin_tune = '0; fin_txo = '0;
    repeat (3) @(negedge clk);
    cmp("R1 busy in reset", {31'd0, busy}, 32'd0);
    cmp("R1 done in reset", {31'd0, done}, 32'd0);
    cmp("R1 req in reset", {31'd0, cmd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    run(16'hFFFF, 16'h0010, 16'h0000, 0, 1'b0);   // R5 code 24
    run(16'h0000, 16'h003A, 16'hFFFF, 1, 1'b0);   // R5 saturate 66->63
    run(16'hA5A5, 16'h0037, 16'h1234, 2, 1'b1);   // R5 exact 63, R2 mid start
    run(16'h5A5A, 16'h0036, 16'h00C0, 3, 1'b0);   // R5 62
    run(16'h1E1E, 16'hFC05, 16'h8001, 1, 1'b0);   // R5 upper bits ignored: 13
    run(16'h0007, 16'h03FF, 16'h0040, 0, 1'b1);   // R5 max status

    // R3: acknowledge while idle is ignored
    cmd_rdata = 16'hBEEF;
    cmd_ack = 1'b1;
    tick();
    repeat (3) tick();
    cmp("R3 idle ack busy", {31'd0, busy}, 32'd0);
    run(16'h3C3C, 16'h0000, 16'h7F7F, 2, 1'b0);   // R5 code 8

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule